// File: doc/BRIEF.md
# Successive Approximation Register Controller

This block is the digital sequencer of an N-bit successive-approximation converter. N is a parameter and defaults to 10. The analog parts sit outside the block. An external DAC turns the trial-code bus into a voltage. An external comparator reports whether the sampled input lies above that voltage.

A one-cycle start request, taken while the block is idle, begins a conversion. The block first proposes half of full scale. It then settles one bit per clock, from the most significant bit down to the least significant. At each step it keeps the bits already accepted and tries the next lower weight. After the last bit it holds the code on a parallel result bus and raises a done pulse for one cycle.

Each decided bit also appears on a serial output as soon as it is known, most significant first. A valid strobe marks every serial bit, and a last flag marks the least significant one. A downstream consumer can therefore begin work before the conversion completes.

Top module: `sar_converter_ctrl`

## Requirements
- R1: After reset, trialCode, resultOut, busyOut, doneOut, serValid, serBit and serLast are all zero.
- R2: A clock edge that samples startIn=1 while busyOut=0 sets busyOut=1 in the following cycle. In that cycle trialCode has only bit N-1 set.
- R3: The comparator input is sampled at each clock edge while busy. compIn=1 (input above the trial level) keeps the bit under trial at 1, and compIn=0 clears it. Except after the final edge, the next trialCode holds every accepted bit and sets the next lower bit, with all lower bits zero.
- R4: A conversion makes exactly N decisions. busyOut stays high for N cycles, and doneOut is high for exactly one cycle, the one after the N-th decision edge, in which busyOut is already 0.
- R5: For an ideal comparator, resultOut equals the largest code c with trial level c below the input. In the cycle where doneOut=1, resultOut equals trialCode, and resultOut holds until the next conversion ends.
- R6: In the cycle after each decision edge, serValid=1 and serBit carries the bit just decided, in order from bit N-1 down to bit 0. serLast=1 only with bit 0, in the same cycle as doneOut. serValid=0 whenever no decision was just made.
- R7: startIn=1 while busyOut=1 is ignored. The conversion in progress keeps its trial sequence, its result and its N-cycle length.
- R8: With N=10, a reference of 1 V and an input of 0.6 V, the first four serial bits are 1, 0, 0, 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Start request, honoured only when idle |
| compIn | input | 1 | Comparator: 1 when the input is above the trial level |
| trialCode | output | N | Trial code driven to the external DAC |
| busyOut | output | 1 | Conversion in progress |
| resultOut | output | N | Parallel result of the last conversion |
| doneOut | output | 1 | One-cycle pulse when resultOut is updated |
| serBit | output | 1 | Serial decided bit, most significant first |
| serValid | output | 1 | serBit is valid this cycle |
| serLast | output | 1 | serBit is the least significant bit |

## Verification
The assertions assume two things about the inputs. compIn is settled at each clock edge during a conversion, so the DAC and comparator respond within one cycle of a trial code change. startIn is a synchronous level that may arrive at any time, including mid-conversion.

The bench drives compIn combinationally from an ideal threshold model of the live trialCode, which meets the one-cycle settling assumption. It changes startIn only at falling clock edges, away from the sampling edge.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             load;
    logic             decide;
    logic             last;
    logic [IDX_W-1:0] idx;
  } sar_strobe_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int N = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startIn,
  output logic                busy,
  output sar_pkg::sar_strobe_t strobe
);
  localparam int IW = sar_pkg::IDX_W;

  logic [IW-1:0] idxQ;
  logic          busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
    end else if (!busyQ) begin
      if (startIn) begin
        busyQ <= 1'b1;
        idxQ  <= IW'(N - 1);
      end
    end else if (idxQ == '0) begin
      busyQ <= 1'b0;
    end else begin
      idxQ <= idxQ - 1'b1;
    end
  end

  always_comb begin
    strobe.load   = startIn && !busyQ;
    strobe.decide = busyQ;
    strobe.last   = busyQ && (idxQ == '0);
    strobe.idx    = idxQ;
  end

  assign busy = busyQ;
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath #(
  parameter int N = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 compIn,
  input  sar_pkg::sar_strobe_t strobe,
  output logic [N-1:0]         code,
  output logic [N-1:0]         result,
  output logic                 done,
  output logic                 serBit,
  output logic                 serValid,
  output logic                 serLast
);
  localparam int IW = sar_pkg::IDX_W;

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic bitQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bitQ <= 1'b0;
      end else if (strobe.load) begin
        bitQ <= (b == N - 1);
      end else if (strobe.decide) begin
        if (strobe.idx == IW'(b)) begin
          bitQ <= compIn;
        end else if (strobe.idx == IW'(b + 1)) begin
          bitQ <= 1'b1;
        end
      end
    end
    assign code[b] = bitQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      done     <= 1'b0;
      serBit   <= 1'b0;
      serValid <= 1'b0;
      serLast  <= 1'b0;
    end else begin
      done     <= strobe.last;
      serValid <= strobe.decide;
      serLast  <= strobe.last;
      serBit   <= strobe.decide ? compIn : 1'b0;
      if (strobe.last) begin
        result <= {code[N-1:1], compIn};
      end
    end
  end
endmodule

// File: rtl/sar_converter_ctrl.sv
module sar_converter_ctrl #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         compIn,
  output logic [N-1:0] trialCode,
  output logic         busyOut,
  output logic [N-1:0] resultOut,
  output logic         doneOut,
  output logic         serBit,
  output logic         serValid,
  output logic         serLast
);
  sar_pkg::sar_strobe_t strobe;

  sar_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .busy(busyOut), .strobe(strobe)
  );

  sar_datapath #(.N(N)) u_dp (
    .clk(clk), .rstN(rstN), .compIn(compIn), .strobe(strobe),
    .code(trialCode), .result(resultOut), .done(doneOut),
    .serBit(serBit), .serValid(serValid), .serLast(serLast)
  );
endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
  parameter int N = 10
) (
  input logic         clk,
  input logic         rstN,
  input logic [N-1:0] trialCode,
  input logic         busyOut,
  input logic [N-1:0] resultOut,
  input logic         doneOut,
  input logic         serValid,
  input logic         serLast
);
  localparam int CW = $clog2(N + 1) + 1;
  localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

  logic [CW-1:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (busyOut) busyCnt <= busyCnt + 1'b1;
    else busyCnt <= '0;
  end

  p_first_trial_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyOut) |-> trialCode == MSB_ONLY);

  p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    busyOut |-> busyCnt < CW'(N));

  p_done_after_n_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (busyCnt == CW'(N)) && !busyOut);

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  p_result_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> resultOut == trialCode);

  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> $stable(resultOut));

  p_last_with_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    serLast |-> serValid && doneOut);

  p_valid_in_conv_r6: assert property (@(posedge clk) disable iff (!rstN)
    (serValid && !serLast) |-> busyOut);
endmodule

bind sar_converter_ctrl sar_checker #(.N(N)) u_sar_checker (
  .clk(clk), .rstN(rstN), .trialCode(trialCode), .busyOut(busyOut),
  .resultOut(resultOut), .doneOut(doneOut), .serValid(serValid),
  .serLast(serLast)
);

// File: tb/sar_converter_ctrl_test.sv
module sar_converter_ctrl_test;
  localparam int N = 10;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic compIn;
  logic [N-1:0] trialCode, resultOut;
  logic busyOut, doneOut, serBit, serValid, serLast;

  int level = 0;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb compIn = (level > 4 * int'(trialCode));

  sar_converter_ctrl #(.N(N)) uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .compIn(compIn),
    .trialCode(trialCode), .busyOut(busyOut), .resultOut(resultOut),
    .doneOut(doneOut), .serBit(serBit), .serValid(serValid), .serLast(serLast)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expectCode(int lvl);
    int c;
    if (lvl <= 0) return 0;
    c = (lvl - 1) / 4;
    if (c > (1 << N) - 1) c = (1 << N) - 1;
    return c;
  endfunction

  task automatic runConv(int lvl, bit noisyStart);
    int exp;
    level = lvl;
    exp = expectCode(lvl);
    @(negedge clk);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check("R2 busy", int'(busyOut), 1);
    check("R2 first trial", int'(trialCode), 1 << (N - 1));
    for (int k = 1; k <= N; k++) begin
      if (noisyStart) startIn = (k >= 2 && k <= N - 2);
      @(negedge clk);
      check("R6 valid", int'(serValid), 1);
      check("R6 bit", int'(serBit), (exp >> (N - k)) & 1);
      check("R6 last", int'(serLast), int'(k == N));
      check("R4 done", int'(doneOut), int'(k == N));
      check("R4 busy", int'(busyOut), int'(k < N));
      if (k < N)
        check("R3 trial", int'(trialCode),
              (exp & ~((1 << (N - k)) - 1)) | (1 << (N - k - 1)));
    end
    startIn = 1'b0;
    check(noisyStart ? "R7 result" : "R5 result", int'(resultOut), exp);
    @(negedge clk);
    check("R4 done drop", int'(doneOut), 0);
    check("R7 idle", int'(busyOut), 0);
    check("R6 valid drop", int'(serValid), 0);
    check("R5 hold", int'(resultOut), exp);
  endtask

  task automatic testReset();
    check("R1 trial", int'(trialCode), 0);
    check("R1 result", int'(resultOut), 0);
    check("R1 busy", int'(busyOut), 0);
    check("R1 done", int'(doneOut), 0);
    check("R1 serial", int'({serValid, serBit, serLast}), 0);
  endtask

  task automatic testExample();
    int first4 = 0;
    level = 2458;
    @(negedge clk);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    for (int k = 1; k <= N; k++) begin
      @(negedge clk);
      if (k <= 4) first4 = (first4 << 1) | int'(serBit);
    end
    check("R8 first four bits", first4, 4'b1001);
    check("R8 result", int'(resultOut), 614);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testExample();
    runConv(2458, 1'b0);
    runConv(0, 1'b0);
    runConv(5000, 1'b0);
    runConv(2048, 1'b0);
    runConv(2049, 1'b0);
    runConv(1301, 1'b1);
    runConv(3, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule